// File: doc/BRIEF.md
# PCI Target Termination Classifier

This block sits beside the initiator side of a parallel, PCI-style bus. It watches the target handshake lines (STOP#, DEVSEL#, TRDY#) and the initiator lines (FRAME#, IRDY#) on every rising clock edge. It reports how each data phase or termination came out, as a one-cycle pulse on one of six outputs. The surrounding master sequencer uses these pulses to decide what comes next: move on to the next data phase, repeat the transaction later, resume at an updated address, drop the request, or flag a bus fault.

The classifier keeps a short history for the current transaction: whether any data phase has completed, whether the target has ever driven DEVSEL#, and whether a termination has already been reported. That history is what separates a retry from a disconnect without data, and a legal target abort from a protocol fault. The history is cleared when FRAME# is asserted after a cycle in which FRAME# and IRDY# were both deasserted.

Top module: `ttc_term_classifier`

## Requirements
- R1: While rst_n is low, and on the first output cycle after it rises, every pulse output is 0. Reset clears all transaction history. A transaction whose FRAME# is already asserted when reset is released counts as a new transaction.
- R2: In a sampled cycle with IRDY#, TRDY# and DEVSEL# low and STOP# high, xfer_pulse is 1 in the following cycle.
- R3: In a sampled cycle with STOP#, DEVSEL#, TRDY# and IRDY# all low, disc_data_pulse is 1 in the following cycle.
- R4: In a sampled cycle with STOP# and DEVSEL# low and TRDY# high, after at least one earlier completed data phase in the same transaction, disc_nodata_pulse is 1 in the following cycle.
- R5: The same STOP#/DEVSEL#/TRDY# pattern as in R4, with no earlier completed data phase in the transaction, gives retry_pulse in the following cycle.
- R6: In a sampled cycle with STOP# low and both DEVSEL# and TRDY# high, abort_pulse is 1 in the following cycle, provided DEVSEL# was low in an earlier sampled cycle of the same transaction.
- R7: proto_err_pulse is 1 in the following cycle in two cases: the R6 pattern with DEVSEL# never seen low in the transaction, or TRDY# low while DEVSEL# is high.
- R8: After a termination (any outcome other than none or xfer), no pulse is produced until a new transaction starts, even while STOP# stays asserted.
- R9: Data and DEVSEL# history from one transaction does not carry into the next. A new transaction starts when FRAME# goes low after a cycle with FRAME# and IRDY# both high.
- R10: A cycle in which IRDY# and DEVSEL# are both high is not sampled and produces no pulse, whatever STOP# and TRDY# are doing.
- R11: At most one pulse output is high in any cycle.
- R12: A sampled cycle with STOP# and TRDY# both high (a wait state) produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| xfer_pulse | output | 1 | Ordinary completed data phase |
| disc_data_pulse | output | 1 | Disconnect with the final data phase completed |
| disc_nodata_pulse | output | 1 | Disconnect after earlier data, with no data this phase |
| retry_pulse | output | 1 | Target asked for the whole transaction to be repeated |
| abort_pulse | output | 1 | Legal target abort |
| proto_err_pulse | output | 1 | Illegal target signalling |

## Verification
The bench builds the block with OUT_REG at its default of 1, so every pulse is registered and appears one clock after the cycle it describes. That setting lets the vector table compare each row's expected pulse at the next falling edge. It also lets the checker compare the pulses against a one-cycle-delayed copy of the bus lines. With that latency, the bench reaches back-to-back transactions where stale data or DEVSEL# history would flip a retry into a disconnect, or a fault into an abort. It also reaches STOP# held across the FRAME# release, and reset released in the middle of a transaction.

// File: rtl/ttc_pkg.sv
// Package: shared types for the target termination classifier.
// Assumes pulse lane n carries the outcome whose kind code is n+1.
package ttc_pkg;

    typedef enum logic [2:0] {
        TK_NONE        = 3'd0,
        TK_XFER        = 3'd1,
        TK_DISC_DATA   = 3'd2,
        TK_DISC_NODATA = 3'd3,
        TK_RETRY       = 3'd4,
        TK_ABORT       = 3'd5,
        TK_PROTO       = 3'd6
    } term_kind_e;

    localparam int unsigned KIND_COUNT = 6;

    localparam int unsigned LANE_XFER        = 0;
    localparam int unsigned LANE_DISC_DATA   = 1;
    localparam int unsigned LANE_DISC_NODATA = 2;
    localparam int unsigned LANE_RETRY       = 3;
    localparam int unsigned LANE_ABORT       = 4;
    localparam int unsigned LANE_PROTO       = 5;

    // True for outcomes that end the transaction's classification.
    function automatic logic is_terminal(input term_kind_e k);
        return (k != TK_NONE) && (k != TK_XFER);
    endfunction

endpackage

// File: rtl/ttc_txn_tracker.sv
// Module: per-transaction history tracker.
// It finds the start of a transaction (FRAME# asserted after an idle cycle)
// and decides which cycles are sampled. It keeps three history bits: data
// moved, DEVSEL# seen, termination reported. The "prior" outputs cover
// earlier cycles of the current transaction only; they read zero on the
// start cycle. Inputs are asserted-high views of the bus lines.
module ttc_txn_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    input  logic irdy,
    input  logic devsel,
    input  logic trdy,
    input  logic term_now,
    output logic sample_en,
    output logic data_prior,
    output logic devsel_prior,
    output logic done_prior
);

    logic idle_q;
    logic data_q;
    logic devsel_q;
    logic done_q;
    logic busy;
    logic start;

    // Bus ownership and transaction start detection.
    always_comb begin
        busy      = frame | irdy;
        start     = frame & idle_q;
        sample_en = busy & (irdy | devsel);
    end

    // History seen by this cycle's classification, cleared on a start.
    always_comb begin
        data_prior   = start ? 1'b0 : data_q;
        devsel_prior = start ? 1'b0 : devsel_q;
        done_prior   = start ? 1'b0 : done_q;
    end

    // Accumulate history for later cycles of the same transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q   <= 1'b1;
            data_q   <= 1'b0;
            devsel_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            idle_q   <= ~busy;
            data_q   <= data_prior | (sample_en & irdy & trdy & devsel);
            devsel_q <= devsel_prior | (sample_en & devsel);
            done_q   <= done_prior | term_now;
        end
    end

endmodule

// File: rtl/ttc_decoder.sv
// Module: combinational outcome decoder.
// It maps one sampled cycle of target signalling, plus the transaction
// history, to a single outcome kind. Assumes asserted-high inputs and
// history that excludes the current cycle.
module ttc_decoder
    import ttc_pkg::*;
(
    input  logic       sample_en,
    input  logic       irdy,
    input  logic       devsel,
    input  logic       trdy,
    input  logic       stop,
    input  logic       data_prior,
    input  logic       devsel_prior,
    input  logic       done_prior,
    output term_kind_e kind,
    output logic       term_now
);

    // Pick exactly one outcome for this cycle.
    always_comb begin
        kind = TK_NONE;
        if (sample_en && !done_prior) begin
            if (stop) begin
                if (devsel) begin
                    if (trdy) begin
                        kind = irdy ? TK_DISC_DATA : TK_NONE;
                    end else begin
                        kind = data_prior ? TK_DISC_NODATA : TK_RETRY;
                    end
                end else begin
                    kind = (devsel_prior && !trdy) ? TK_ABORT : TK_PROTO;
                end
            end else if (trdy) begin
                if (!devsel) begin
                    kind = TK_PROTO;
                end else if (irdy) begin
                    kind = TK_XFER;
                end
            end
        end
    end

    // Flag outcomes that close the transaction for reporting.
    always_comb begin
        term_now = is_terminal(kind);
    end

endmodule

// File: rtl/ttc_pulse_stage.sv
// Module: outcome-to-pulse expander.
// It turns the outcome kind into one-hot pulse lanes. OUT_REG=1 registers
// the lanes (one cycle of latency); OUT_REG=0 passes them straight through.
module ttc_pulse_stage
    import ttc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  term_kind_e            kind,
    output logic [KIND_COUNT-1:0] pulses
);

    logic [KIND_COUNT-1:0] lane_hot;

    for (genvar g = 0; g < KIND_COUNT; g++) begin : g_lane
        // Lane g is hot when the kind code equals g+1.
        assign lane_hot[g] = (kind == term_kind_e'(3'(g + 1)));
    end

    if (OUT_REG) begin : g_reg
        // Register the lanes so pulses leave the block from flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulses <= '0;
            end else begin
                pulses <= lane_hot;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign pulses = lane_hot;
    end

endmodule

// File: rtl/ttc_term_classifier.sv
// Module: top of the target termination classifier.
// It watches the target handshake of a transaction owned by the local
// initiator and emits one pulse per classified cycle. All bus inputs are
// active low and assumed synchronous to clk.
module ttc_term_classifier
    import ttc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic devsel_n,
    input  logic trdy_n,
    input  logic stop_n,
    output logic xfer_pulse,
    output logic disc_data_pulse,
    output logic disc_nodata_pulse,
    output logic retry_pulse,
    output logic abort_pulse,
    output logic proto_err_pulse
);

    logic                  frame, irdy, devsel, trdy, stop;
    logic                  sample_en, data_prior, devsel_prior, done_prior;
    logic                  term_now;
    term_kind_e            kind;
    logic [KIND_COUNT-1:0] pulses;

    // Convert active-low bus lines to asserted-high views.
    always_comb begin
        frame  = ~frame_n;
        irdy   = ~irdy_n;
        devsel = ~devsel_n;
        trdy   = ~trdy_n;
        stop   = ~stop_n;
    end

    ttc_txn_tracker u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame        (frame),
        .irdy         (irdy),
        .devsel       (devsel),
        .trdy         (trdy),
        .term_now     (term_now),
        .sample_en    (sample_en),
        .data_prior   (data_prior),
        .devsel_prior (devsel_prior),
        .done_prior   (done_prior)
    );

    ttc_decoder u_dec (
        .sample_en    (sample_en),
        .irdy         (irdy),
        .devsel       (devsel),
        .trdy         (trdy),
        .stop         (stop),
        .data_prior   (data_prior),
        .devsel_prior (devsel_prior),
        .done_prior   (done_prior),
        .kind         (kind),
        .term_now     (term_now)
    );

    ttc_pulse_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .pulses (pulses)
    );

    // Fan the pulse lanes out to the named ports.
    always_comb begin
        xfer_pulse        = pulses[LANE_XFER];
        disc_data_pulse   = pulses[LANE_DISC_DATA];
        disc_nodata_pulse = pulses[LANE_DISC_NODATA];
        retry_pulse       = pulses[LANE_RETRY];
        abort_pulse       = pulses[LANE_ABORT];
        proto_err_pulse   = pulses[LANE_PROTO];
    end

endmodule

// File: rtl/ttc_checker.sv
// Module: assertion checker bound to ttc_term_classifier.
// It lines each pulse up with the bus cycle that caused it (delayed by one
// clock when OUT_REG=1) and checks the pulse against that cycle's lines.
module ttc_checker #(
    parameter bit OUT_REG = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic frame_n,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic xfer_pulse,
    input logic disc_data_pulse,
    input logic disc_nodata_pulse,
    input logic retry_pulse,
    input logic abort_pulse,
    input logic proto_err_pulse
);

    logic       v_irdy_n, v_devsel_n, v_trdy_n, v_stop_n;
    logic [5:0] pulses;
    logic       term_any;
    logic       unused_frame;

    assign pulses   = {proto_err_pulse, abort_pulse, retry_pulse,
                       disc_nodata_pulse, disc_data_pulse, xfer_pulse};
    assign term_any = proto_err_pulse | abort_pulse | retry_pulse |
                      disc_nodata_pulse | disc_data_pulse;
    assign unused_frame = frame_n;

    if (OUT_REG) begin : g_view_reg
        // Hold the bus lines of the cycle that produced the current pulse.
        always_ff @(posedge clk) begin
            v_irdy_n   <= irdy_n;
            v_devsel_n <= devsel_n;
            v_trdy_n   <= trdy_n;
            v_stop_n   <= stop_n;
        end
    end else begin : g_view_comb
        assign v_irdy_n   = irdy_n;
        assign v_devsel_n = devsel_n;
        assign v_trdy_n   = trdy_n;
        assign v_stop_n   = stop_n;
    end

    p_onehot_pulses_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    p_unsampled_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_irdy_n && v_devsel_n) |-> (pulses == 6'd0));

    p_xfer_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |-> (!v_irdy_n && !v_trdy_n && !v_devsel_n && v_stop_n));

    p_disc_data_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disc_data_pulse |-> (!v_irdy_n && !v_trdy_n && !v_devsel_n && !v_stop_n));

    p_retry_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> (!v_stop_n && !v_devsel_n && v_trdy_n));

    p_abort_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!v_stop_n && v_devsel_n && v_trdy_n));

    p_single_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_any |=> (pulses == 6'd0));

endmodule

bind ttc_term_classifier ttc_checker #(.OUT_REG(OUT_REG)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .frame_n           (frame_n),
    .irdy_n            (irdy_n),
    .devsel_n          (devsel_n),
    .trdy_n            (trdy_n),
    .stop_n            (stop_n),
    .xfer_pulse        (xfer_pulse),
    .disc_data_pulse   (disc_data_pulse),
    .disc_nodata_pulse (disc_nodata_pulse),
    .retry_pulse       (retry_pulse),
    .abort_pulse       (abort_pulse),
    .proto_err_pulse   (proto_err_pulse)
);

// File: tb/tb_ttc_term_classifier.sv
`timescale 1ns/1ps
// Bench: walks a stimulus/expectation table, then directed reset cases.
// Row layout: {frame_n, irdy_n, devsel_n, trdy_n, stop_n} then expected
// {proto, abort, retry, disc_nodata, disc_data, xfer} for the next cycle.
module tb_ttc_term_classifier;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic xfer_pulse, disc_data_pulse, disc_nodata_pulse, retry_pulse, abort_pulse, proto_err_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ttc_term_classifier #(.OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .xfer_pulse(xfer_pulse), .disc_data_pulse(disc_data_pulse),
        .disc_nodata_pulse(disc_nodata_pulse), .retry_pulse(retry_pulse),
        .abort_pulse(abort_pulse), .proto_err_pulse(proto_err_pulse)
    );

    localparam int N = 35;
    localparam logic [10:0] VEC [0:N-1] = '{
        11'b11111_000000,                                      // idle R10
        11'b01111_000000, 11'b00001_000001, 11'b00001_000001,  // R2 burst
        11'b00010_000100, 11'b10010_000000, 11'b11111_000000,  // R4, R8
        11'b01111_000000, 11'b00111_000000, 11'b00010_001000,  // R12, R5
        11'b10010_000000, 11'b11111_000000,
        11'b01111_000000, 11'b00011_000000, 11'b00000_000010,  // R12, R3
        11'b10110_000000, 11'b11111_000000,                    // R8
        11'b01111_000000, 11'b00010_001000, 11'b10010_000000,  // R9 retry
        11'b11111_000000,
        11'b01111_000000, 11'b00011_000000, 11'b00110_010000,  // R6
        11'b10110_000000, 11'b11111_000000,
        11'b01111_000000, 11'b00110_100000, 11'b10110_000000,  // R7, R9
        11'b11111_000000,
        11'b01111_000000, 11'b01110_000000, 11'b00101_100000,  // R10, R7
        11'b10101_000000, 11'b11111_000000                     // R8
    };

    function automatic logic [5:0] outs();
        return {proto_err_pulse, abort_pulse, retry_pulse,
                disc_nodata_pulse, disc_data_pulse, xfer_pulse};
    endfunction

    task automatic drive(input logic [4:0] v);
        {frame_n, irdy_n, devsel_n, trdy_n, stop_n} = v;
    endtask

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        // R1: outputs quiet while held in reset.
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), 6'b0);

        // Table walk; each row's result is seen one edge later.
        for (int i = 0; i < N; i++) begin
            drive(VEC[i][10:6]);
            @(negedge clk);
            check($sformatf("row %0d R2-class", i), outs(), VEC[i][5:0]);
            check($sformatf("row %0d R11", i), 6'($countones(outs()) > 1), 6'b0);
        end

        // R1 and R9: reset in mid-transaction clears the data history.
        drive(5'b01111);
        @(negedge clk);
        drive(5'b00001);
        @(negedge clk);
        check("R2 before mid reset", outs(), 6'b000001);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset quiet", outs(), 6'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(5'b00010);
        @(negedge clk);
        check("R1 retry after reset", outs(), 6'b001000);
        drive(5'b10010);
        @(negedge clk);
        check("R8 stop held after retry", outs(), 6'b0);
        drive(5'b11111);
        @(negedge clk);
        check("R10 idle", outs(), 6'b0);

        summary();
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule